// File: doc/BRIEF.md
# Four-Section Pin I/O Controller with Interrupts

This block drives and samples 32 general-purpose pins over a small 32-bit register bus. The pins are grouped into four sections of eight. Each section has its own identical register bank, and each bank sits in a 64-byte address window. Pin n belongs to section n>>3 at bit n&7. For every pin, software chooses the direction, sets an output value and reads back a synchronized sample of the pad. The pad tri-state buffers are built outside the block. The block hands them an output-enable vector and an output-data vector.

Each section also watches its pins for interrupt events. A pin can detect events in one of two modes. In rising-edge mode a captured event stays set until software clears it. In level mode the event bit stays asserted for as long as the pin is high. Per-pin mask bits gate the status into a masked view. One registered interrupt line combines the masked status of all four sections.

The bus is word-wide with no byte lanes. A write takes effect at the clock edge where the write strobe is high. Read data is registered and appears one clock after the address.

Top module: `pin_ctrl_top`

## Requirements
- R1: While reset is high and on the first cycle after it, every pin is an input (`pin_oe` = 0), every output latch is 0 (`pin_out` = 0), every mask bit is 1, every status bit is 0, every pin is in edge mode, and `irq` is 0.
- R2: Address bits [7:6] select the section and bits [5:0] select the register in that section. Bit b of section s controls pin 8*s+b, so bit 2 of section 1 is pin 10.
- R3: The direction register at offset 0x10 is read/write. A bit value of 1 makes the pin an input and 0 makes it an output. `pin_oe` is the inverse of the direction bits.
- R4: The output latch at offset 0x14 is read/write and drives `pin_out` directly.
- R5: Offset 0x18 reads the pad level after a two-flop synchronizer, so a pad change is visible on a read issued three cycles later. Writes to offset 0x18 are ignored.
- R6: A pin in edge mode sets its status bit when its synchronized level goes from 0 to 1. The bit stays set after the pin falls.
- R7: Offset 0x04 reads the raw status. A write there clears exactly the status bits written as 1.
- R8: Offset 0x08 reads the mask, and a write there sets the mask bits written as 1. A write to offset 0x0C clears the mask bits written as 1. Offset 0x0C reads as 0.
- R9: Offset 0x00 is read-only and returns status AND NOT mask.
- R10: Offset 0x20 is the read/write mode register, where 1 selects level mode and 0 selects edge mode. A pin in level mode holds its status bit at 1 while its synchronized level is high, and clearing the bit takes effect only once the level has dropped.
- R11: `irq` is the OR of the masked status over all four sections. It is registered, so it follows the masked status one cycle later.
- R12: Reads of unmapped offsets (0x1C, 0x24 to 0x3C) return 0, and writes to them change nothing. Bits [31:8] of every read are 0.
- R13: `bus_rdata` shows the register selected by the address of the previous cycle, with the state that register held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address: section in [7:6], register offset in [5:0] |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, low 8 bits used |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad levels, asynchronous |
| pin_oe | output | 32 | Output enable per pin, 1 drives the pad |
| pin_out | output | 32 | Output data per pin |
| irq | output | 1 | Combined masked interrupt |

## Verification
A behavioural model in the bench runs alongside the design and is compared against it on every clock.

The stimulus covers several cases:
- The pin-10 mapping case tells a correct section and bit split apart from a swapped or shifted one.
- Distinct input words read back through the four windows show whether the sections are decoded independently.
- Single-pin rising and falling pulses tell edge capture apart from level following.
- A level-mode pin held high while software clears its bit tells a held status apart from a plain sticky one.
- Mask set/clear writes that use a bit other than the active one show that the write-one actions touch only the addressed bits.
- Writes to unmapped and read-only offsets show that such writes have no side effect.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
  localparam int OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_MSTAT = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_MSET  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_DIR   = 6'h10;
  localparam logic [OFF_W-1:0] OFF_OUT   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IN    = 6'h18;
  localparam logic [OFF_W-1:0] OFF_MODE  = 6'h20;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_section.sv
module pin_section
  import pin_ctrl_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [PINS-1:0]  wdata,
  input  logic [PINS-1:0]  sin,
  output logic [PINS-1:0]  rdata,
  output logic [PINS-1:0]  dir_o,
  output logic [PINS-1:0]  out_o,
  output logic [PINS-1:0]  mstat_o
);
  logic [PINS-1:0] dir_q, out_q, msk_q, sts_q, mode_q, prev_q;
  logic [PINS-1:0] set_v, clr_v;

  // level-mode pins raise while high; edge-mode pins only on a 0->1 step
  assign set_v = sin & (mode_q | ~prev_q);
  assign clr_v = (wr_en && off == OFF_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      out_q  <= '0;
      msk_q  <= '1;
      sts_q  <= '0;
      mode_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= sin;
      sts_q  <= (sts_q & ~clr_v) | set_v;
      if (wr_en) begin
        case (off)
          OFF_MSET: msk_q  <= msk_q | wdata;
          OFF_MCLR: msk_q  <= msk_q & ~wdata;
          OFF_DIR:  dir_q  <= wdata;
          OFF_OUT:  out_q  <= wdata;
          OFF_MODE: mode_q <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      OFF_MSTAT: rdata = sts_q & ~msk_q;
      OFF_STAT:  rdata = sts_q;
      OFF_MSET:  rdata = msk_q;
      OFF_DIR:   rdata = dir_q;
      OFF_OUT:   rdata = out_q;
      OFF_IN:    rdata = sin;
      OFF_MODE:  rdata = mode_q;
      default:   rdata = '0;
    endcase
  end

  assign dir_o   = dir_q;
  assign out_o   = out_q;
  assign mstat_o = sts_q & ~msk_q;

  // R6
  sts_cause_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & ~$past(sts_q) &
              ~($past(sin) & ($past(mode_q) | ~$past(prev_q)))) == '0));

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(mode_q & sin) & ~sts_q) == '0));

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == OFF_MSET) |=> ((msk_q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/pin_ctrl_top.sv
module pin_ctrl_top
  import pin_ctrl_pkg::*;
#(
  parameter int NUM_SECT = 4,
  parameter int SECT_W   = 8,
  parameter int DATA_W   = 32,
  parameter int SYNC_N   = 2,
  localparam int SEL_W   = $clog2(NUM_SECT),
  localparam int ADDR_W  = SEL_W + OFF_W,
  localparam int NPIN    = NUM_SECT * SECT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_out,
  output logic              irq
);
  logic [SEL_W-1:0]  sect;
  logic [OFF_W-1:0]  off;
  logic [NPIN-1:0]   pin_s, dir_all, mstat_all;
  logic [SECT_W-1:0] sec_rd [NUM_SECT];
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;
  logic              unused_wbits;

  assign sect         = bus_addr[ADDR_W-1:OFF_W];
  assign off          = bus_addr[OFF_W-1:0];
  assign unused_wbits = ^bus_wdata[DATA_W-1:SECT_W];

  pin_sync #(.W(NPIN), .STAGES(SYNC_N)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    pin_section #(.PINS(SECT_W)) i_sect (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_wr && sect == SEL_W'(s)),
      .off     (off),
      .wdata   (bus_wdata[SECT_W-1:0]),
      .sin     (pin_s[s*SECT_W +: SECT_W]),
      .rdata   (sec_rd[s]),
      .dir_o   (dir_all[s*SECT_W +: SECT_W]),
      .out_o   (pin_out[s*SECT_W +: SECT_W]),
      .mstat_o (mstat_all[s*SECT_W +: SECT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= {{(DATA_W-SECT_W){1'b0}}, sec_rd[sect]};
      irq_q   <= |mstat_all;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign pin_oe    = ~dir_all;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && !irq && bus_rdata == '0));
endmodule

// File: tb/test_pin_ctrl_top.sv
module test_pin_ctrl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h3C;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] rdata, pin_oe, pin_out;
  logic        irq;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    started = 1'b0;

  always #5 clk = ~clk;

  pin_ctrl_top i_pin_ctrl_top (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]  m_dir [4], m_out [4], m_msk [4], m_sts [4], m_mode [4];
  logic [31:0] m_s1, m_s2, m_prev, m_rd;
  logic        m_irq;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      for (int k = 0; k < 4; k++) begin
        m_dir[k] = 8'hFF; m_out[k] = 0; m_msk[k] = 8'hFF; m_sts[k] = 0; m_mode[k] = 0;
      end
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_rd = 0; m_irq = 0;
    end else begin
      int sec;
      int off;
      logic any;
      sec = addr[7:6];
      off = addr[5:0];
      case (off)
        'h00: m_rd = {24'h0, m_sts[sec] & ~m_msk[sec]};
        'h04: m_rd = {24'h0, m_sts[sec]};
        'h08: m_rd = {24'h0, m_msk[sec]};
        'h10: m_rd = {24'h0, m_dir[sec]};
        'h14: m_rd = {24'h0, m_out[sec]};
        'h18: m_rd = {24'h0, m_s2[sec*8 +: 8]};
        'h20: m_rd = {24'h0, m_mode[sec]};
        default: m_rd = 0;
      endcase
      any = 0;
      for (int k = 0; k < 4; k++) if ((m_sts[k] & ~m_msk[k]) != 0) any = 1;
      m_irq = any;
      for (int p = 0; p < 32; p++) begin
        int k;
        int b;
        logic hit;
        k = p / 8;
        b = p % 8;
        if (wr && sec == k && off == 'h04 && wdata[b]) m_sts[k][b] = 0;
        hit = m_s2[p] && (m_mode[k][b] || !m_prev[p]);
        if (hit) m_sts[k][b] = 1;
      end
      if (wr) begin
        case (off)
          'h08: m_msk[sec] = m_msk[sec] | wdata[7:0];
          'h0C: m_msk[sec] = m_msk[sec] & ~wdata[7:0];
          'h10: m_dir[sec] = wdata[7:0];
          'h14: m_out[sec] = wdata[7:0];
          'h20: m_mode[sec] = wdata[7:0];
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  // R13: every port compared with the model on every cycle
  always @(negedge clk) begin
    if (started) begin
      logic [31:0] e_oe, e_out;
      for (int k = 0; k < 4; k++) begin
        e_oe[k*8 +: 8]  = ~m_dir[k];
        e_out[k*8 +: 8] = m_out[k];
      end
      n_vec++;
      if (rdata !== m_rd || pin_oe !== e_oe || pin_out !== e_out || irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s/R13 model: rdata %h/%h oe %h/%h out %h/%h irq %b/%b (actual/expected)",
                 cur_req, rdata, m_rd, pin_oe, e_oe, pin_out, e_out, irq, m_irq);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 8'h3C;
  endtask

  task automatic brd(input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; wr = 1'b0;
    @(negedge clk); chk(rdata, exp, $sformatf("read %h", a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    cur_req = "R1";
    chk(pin_oe, 32'h0, "pin_oe after reset");
    chk(pin_out, 32'h0, "pin_out after reset");
    brd(8'h08, 32'hFF); brd(8'hC8, 32'hFF);
    brd(8'h10, 32'hFF); brd(8'h44, 32'h00); brd(8'hA0, 32'h00);

    cur_req = "R2";
    bwr(8'h50, 32'hFB); bwr(8'h54, 32'h04);
    chk(pin_oe, 32'h0000_0400, "pin 10 enable");
    chk(pin_out, 32'h0000_0400, "pin 10 data");

    cur_req = "R3";
    bwr(8'h10, 32'h0F);
    chk(pin_oe, 32'h0000_04F0, "direction 1=input");
    brd(8'h10, 32'h0F);

    cur_req = "R4";
    bwr(8'h14, 32'hA5); bwr(8'h94, 32'h3C);
    brd(8'h14, 32'hA5);
    chk(pin_out, 32'h003C_04A5, "latch drives pins");

    cur_req = "R5";
    pin_in = 32'h1234_5678;
    idle(3);
    brd(8'h58, 32'h56); brd(8'hD8, 32'h12);
    bwr(8'h18, 32'hFF);
    brd(8'h18, 32'h78);

    cur_req = "R6";
    pin_in = 0; idle(4);
    for (int k = 0; k < 4; k++) bwr(8'(k*64 + 4), 32'hFF);
    brd(8'h04, 32'h00);
    pin_in[3] = 1'b1; idle(4);
    brd(8'h04, 32'h08);
    pin_in[3] = 1'b0; idle(4);
    brd(8'h04, 32'h08);

    cur_req = "R9";
    brd(8'h00, 32'h00);
    bwr(8'h00, 32'hFF);
    brd(8'h04, 32'h08);

    cur_req = "R8";
    bwr(8'h0C, 32'h08);
    brd(8'h08, 32'hF7); brd(8'h0C, 32'h00);
    cur_req = "R9";
    brd(8'h00, 32'h08);

    cur_req = "R11";
    idle(1);
    chk({31'h0, irq}, 32'h1, "irq from section 0");

    cur_req = "R7";
    bwr(8'h04, 32'h01);
    brd(8'h04, 32'h08);
    bwr(8'h04, 32'h08);
    brd(8'h04, 32'h00);
    cur_req = "R11";
    chk({31'h0, irq}, 32'h0, "irq after clear");

    cur_req = "R8";
    bwr(8'h08, 32'h08);
    brd(8'h08, 32'hFF);

    cur_req = "R10";
    bwr(8'hA0, 32'h01);
    brd(8'hA0, 32'h01);
    pin_in[16] = 1'b1; idle(4);
    brd(8'h84, 32'h01);
    bwr(8'h84, 32'h01);
    brd(8'h84, 32'h01);
    pin_in[16] = 1'b0; idle(4);
    brd(8'h84, 32'h01);
    bwr(8'h84, 32'h01);
    brd(8'h84, 32'h00);

    cur_req = "R11";
    bwr(8'hCC, 32'h80);
    pin_in[31] = 1'b1; idle(5);
    chk({31'h0, irq}, 32'h1, "irq from section 3");
    brd(8'hC0, 32'h80);

    cur_req = "R12";
    brd(8'h1C, 32'h0); brd(8'h3C, 32'h0);
    bwr(8'h24, 32'hFFFF_FFFF);
    brd(8'h24, 32'h0);
    brd(8'h10, 32'h0F);
    brd(8'h08, 32'hFF);
    idle(2);
    done();
  end
endmodule